// File: doc/BRIEF.md
# Extended-Range Multi-Modulus Integer Divider

This block divides an input clock by a programmable integer for the feedback path of a frequency synthesizer loop. It is one continuous chain of divide-by-2/3 stages. A modulus-control flag runs from the top of the chain back down to the first stage. It is not a prescaler paired with a program counter and a swallow counter, so every integer ratio from 3 up to 2048 can be reached without gaps.

The chain length is not fixed. The most significant set bit of the programmed ratio selects how many stages take part. Stages above that bit are bypassed, and their modulus flag is held active. This range extension lets a chain with a 2^n to 2^(n+1)-1 span reach the small ratios as well. In each output period every active stage counts two input events from the stage below it. While the modulus flag arriving from above is active and the stage's program bit is 1, that stage counts three events instead. The output pulse marks the point where every active stage completes its last group at the same time.

The 11-bit ratio word is taken only at period boundaries, so a period never mixes two ratios. The reset is asynchronous and active low. Its release is expected to be synchronous to the clock.

Top module: `mmd_divider`

## Requirements
- R1: For a ratio word W with 3 <= W <= 2047, `div_pulse` is high for exactly one input cycle out of every W input cycles, including W = 3, 4, 7, 8, 1023, 1024 and 2047.
- R2: The all-zero ratio word gives a period of 2048 input cycles.
- R3: Ratio words 1 and 2 give a period of 3 input cycles.
- R4: `div_pulse` is never high in two consecutive cycles.
- R5: A change of `ratio_word` in the middle of a period does not alter that period. The period that begins with the next pulse, and the periods after it, use the new word.
- R6: After `rst_n` is released, the first pulse appears after exactly W rising clock edges. W is the value of `ratio_word` at the first edge.
- R7: While `rst_n` is low, `div_pulse` is low.
- R8: The number of active stages follows the position of the most significant 1 of the effective ratio. Ratios on either side of a power of two (7/8, 1023/1024) keep exact periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ratio_word | input | 11 | Division ratio; 0 means 2048, 1 and 2 mean 3 |
| div_pulse | output | 1 | One-cycle pulse, once per output period |

## Verification
A stage counter that is corrupted, or a stage left active above the top set bit, changes the number of input cycles between two pulses. The spacing check detects this at the first pulse after the fault, at most one output period later. A load of the ratio word at the wrong time shows up as one period that has neither the old length nor the new one. A fault in the chain's modulus flag shows up as a period that is off by a power of two. Every spacing between consecutive pulses is measured against the ratio in force for that period.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int WORD_W    = 11;
  localparam int RATIO_W   = WORD_W + 1;
  localparam int STAGES    = WORD_W;
  localparam int MIN_RATIO = 3;
  localparam int CNT_W     = 2;
endpackage

// File: rtl/mmd_ratio_decode.sv
module mmd_ratio_decode #(
  parameter int WORD_W  = mmd_pkg::WORD_W,
  parameter int MIN_RAT = mmd_pkg::MIN_RATIO,
  localparam int RATIO_W = WORD_W + 1
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [RATIO_W-1:0] FULL  = RATIO_W'(1) << WORD_W;
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RAT);

  always_comb begin
    if (word_i == '0)
      ratio_o = FULL;
    else if ({1'b0, word_i} < FLOOR)
      ratio_o = FLOOR;
    else
      ratio_o = {1'b0, word_i};
  end

  // R3: the decoded ratio never falls below the floor
  always_comb begin
    assert (ratio_o >= FLOOR)
      else $error("p_ratio_floor_r3");
  end
endmodule

// File: rtl/mmd_stage.sv
module mmd_stage #(
  parameter int CNT_W = mmd_pkg::CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic prog_i,
  input  logic adv_i,
  input  logic fin_up_i,
  output logic adv_o,
  output logic fin_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stretch;
  logic             last;

  // group of three only while the flag from above is active and the bit is set
  assign stretch = prog_i & fin_up_i;
  assign last    = ~active_i | (cnt_q == (stretch ? CNT_W'(2) : CNT_W'(1)));
  assign adv_o   = adv_i & last;
  assign fin_o   = fin_up_i & last;

  always_comb begin
    cnt_d = cnt_q;
    if (!active_i)
      cnt_d = '0;
    else if (adv_i)
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R1: a stage never counts past three events
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != CNT_W'(3));

  // R1: a third event is only reached by a stage whose program bit is set
  p_third_needs_prog_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(2)) |-> prog_i);

  // R8: a bypassed stage holds no count
  p_idle_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && $past(!active_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int WORD_W = mmd_pkg::WORD_W,
  localparam int RATIO_W = WORD_W + 1,
  localparam int STAGES  = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ratio_word,
  output logic              div_pulse
);
  logic [RATIO_W-1:0] live_ratio;
  logic [RATIO_W-1:0] cfg_q, cfg_d;
  logic [RATIO_W-1:0] eff_ratio;
  logic               running_q;
  logic               pulse_q;
  logic               boundary;
  logic               load_en;
  logic [STAGES-1:0]  active;
  logic [STAGES-1:0]  prog;
  logic [STAGES:0]    adv;
  logic [STAGES:0]    fin;

  mmd_ratio_decode #(.WORD_W(WORD_W)) i_decode (
    .word_i  (ratio_word),
    .ratio_o (live_ratio)
  );

  // before the first edge the chain runs from the live word
  assign eff_ratio = running_q ? cfg_q : live_ratio;

  assign adv[0]      = 1'b1;
  assign fin[STAGES] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign active[i] = |eff_ratio[RATIO_W-1:i+1];
    assign prog[i]   = eff_ratio[i];

    mmd_stage i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active[i]),
      .prog_i   (prog[i]),
      .adv_i    (adv[i]),
      .fin_up_i (fin[i+1]),
      .adv_o    (adv[i+1]),
      .fin_o    (fin[i])
    );
  end

  assign boundary = fin[0];
  assign load_en  = boundary | ~running_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load_en)
      cfg_d = live_ratio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      running_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      running_q <= 1'b1;
      pulse_q   <= boundary;
    end
  end

  assign div_pulse = pulse_q;

  // checker state: edges since the last pulse and the ratio of the closing period
  logic [RATIO_W:0]   span_q;
  logic [RATIO_W-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
      per_q  <= '0;
    end else begin
      span_q <= pulse_q ? (RATIO_W+1)'(1) : span_q + (RATIO_W+1)'(1);
      if (boundary)
        per_q <= eff_ratio;
    end
  end

  // R1 R2 R6: each pulse closes a span equal to the ratio of that period
  p_period_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (span_q == {1'b0, per_q}));

  // R4: pulses are isolated
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R5: the held ratio moves only after a boundary or the first edge
  p_load_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !$stable(cfg_q)) |-> $past(load_en));
endmodule

// File: tb/test_mmd_divider.sv
module test_mmd_divider;
  localparam int WORD_W = 11;
  localparam int NVEC   = 12;
  localparam int LIMIT  = 5000;
  localparam int unsigned VEC_WORD [NVEC] =
    '{3, 4, 7, 8, 5, 100, 1023, 1024, 2047, 0, 1, 2};
  localparam int unsigned VEC_EXP  [NVEC] =
    '{3, 4, 7, 8, 5, 100, 1023, 1024, 2047, 2048, 3, 3};

  logic              clk = 1'b0;
  logic              rst_n;
  logic [WORD_W-1:0] ratio_word;
  logic              div_pulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mmd_divider i_mmd_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_word (ratio_word),
    .div_pulse  (div_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < LIMIT);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n;
    int prev;
    rst_n      = 1'b0;
    ratio_word = 11'd5;
    // R7: quiet while held in reset
    repeat (4) begin
      @(negedge clk);
      check("R7 reset low", int'(div_pulse), 0);
    end
    rst_n = 1'b1;
    // R6: first pulse after N edges
    gap(n);
    check("R6 first pulse", n, 5);
    gap(n);
    check("R1 steady 5", n, 5);
    prev = 5;

    // table walk: one transitional period at the old ratio, then two new ones
    for (int k = 0; k < NVEC; k++) begin
      ratio_word = WORD_W'(VEC_WORD[k]);
      gap(n);
      check("R5 old ratio holds", n, prev);
      gap(n);
      check("R1 R2 R3 R8 ratio", n, int'(VEC_EXP[k]));
      gap(n);
      check("R1 R2 R3 R8 ratio repeat", n, int'(VEC_EXP[k]));
      prev = int'(VEC_EXP[k]);
    end

    // R5: change mid-period
    ratio_word = 11'd1000;
    gap(n);
    gap(n);
    check("R5 setup 1000", n, 1000);
    repeat (10) @(negedge clk);
    ratio_word = 11'd7;
    gap(n);
    check("R5 mid-period change ignored", n + 10, 1000);
    gap(n);
    check("R5 new ratio applied", n, 7);

    // R4: no two consecutive high cycles at the smallest ratio
    ratio_word = 11'd3;
    gap(n);
    gap(n);
    begin
      int dbl = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (div_pulse) begin
          @(negedge clk);
          if (div_pulse) dbl++;
        end
      end
      check("R4 isolated pulses", dbl, 0);
    end

    // R6 with reset under a large ratio, R7 mid-run
    ratio_word = 11'd1024;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset clears pulse", int'(div_pulse), 0);
    rst_n = 1'b1;
    gap(n);
    check("R6 first pulse 1024", n, 1024);

    finish_run();
  end
endmodule